// File: doc/BRIEF.md
# Texture LOD Bias Lookup Stage

This stage sits ahead of texel address generation in a texture unit. For every texel request it takes the level-0 integer coordinate (u, v), the integer and fractional parts of the computed level of detail, and the coarsest level the bound texture actually has. It reads a 2-bit bias from a small complexity pyramid, adds that bias to the requested level so that smooth regions are served from a coarser and smaller mipmap, and produces the adjusted level pair and the coordinates scaled to both levels. These outputs go to the texel fetch and the trilinear filter.

The bias pyramid has the same per-level dimensions as the texture's mipmap chain. It is filled beforehand through a simple write port. The stage accepts one request per clock and returns each result exactly two cycles later. The only storage that the request path reads is the synchronous bias memory read.

Top module: `tex_lod_bias_stage`

## Requirements
- R1: A request is accepted in every cycle in which `req_valid` is 1. `out_valid` is 1 exactly two clock edges after the edge that sampled the request, and results come out in request order.
- R2: A write with `bias_wr_en` = 1 stores `bias_wr_data` at the flat entry `bias_wr_addr`. A request sampled at the same edge as a write to the entry it reads sees the old bias. Requests sampled at later edges see the new bias.
- R3: The bias is read at lookup level L = min(`req_lod_int`, `req_max_lvl`). For an edge of 2^TEX_LOG2 texels, the flat entry is base(L) + (v>>L)·2^(TEX_LOG2−L) + (u>>L), where base(L) is the sum of 4^(TEX_LOG2−k) over k < L. Each level is stored row-major, with the finest level first.
- R4: A 2-bit bias b (0 to 3) moves the request b levels coarser. `out_lvl_lo` = min(`req_lod_int` + b, `req_max_lvl`), so it is never finer than the requested level unless that level is above the maximum.
- R5: `out_clamped` is 1 exactly when `req_lod_int` + b exceeds `req_max_lvl`. When `out_clamped` is 1, `out_lvl_lo` equals `req_max_lvl`.
- R6: `out_u_lo` = u >> `out_lvl_lo` and `out_v_lo` = v >> `out_lvl_lo`.
- R7: The second filter level `out_lvl_hi` is `out_lvl_lo` + 1 when `out_lvl_lo` < `req_max_lvl`, and `out_lvl_lo` otherwise. `out_u_hi` and `out_v_hi` are u and v shifted right by `out_lvl_hi`.
- R8: `out_lod_frac` equals `req_lod_frac` of the same request, unchanged.
- R9: While reset is held and in the first cycle after it, `out_valid` is 0 and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_u | input | TEX_LOG2 | Level-0 texel column |
| req_v | input | TEX_LOG2 | Level-0 texel row |
| req_lod_int | input | LVL_W | Integer part of requested level |
| req_lod_frac | input | FRAC_W | Fractional part of requested level |
| req_max_lvl | input | LVL_W | Coarsest level present for this texture |
| bias_wr_en | input | 1 | Bias memory write strobe |
| bias_wr_addr | input | ADDR_W | Flat bias entry index |
| bias_wr_data | input | 2 | Bias value to store |
| out_valid | output | 1 | Result present |
| out_lvl_lo | output | LVL_W | Adjusted (finer) filter level |
| out_lvl_hi | output | LVL_W | Neighbouring coarser filter level |
| out_lod_frac | output | FRAC_W | Fractional level, passed through |
| out_u_lo | output | TEX_LOG2 | Column at `out_lvl_lo` |
| out_v_lo | output | TEX_LOG2 | Row at `out_lvl_lo` |
| out_u_hi | output | TEX_LOG2 | Column at `out_lvl_hi` |
| out_v_hi | output | TEX_LOG2 | Row at `out_lvl_hi` |
| out_clamped | output | 1 | Adjusted level hit the maximum |

## Verification
The properties assume that `req_valid` and `bias_wr_en` stay 0 while reset is held. They also assume that `req_max_lvl` never exceeds TEX_LOG2, that write addresses stay inside the pyramid, and that every entry a request reads has been written before. The stimulus preloads the whole pyramid before it sends any request. It draws the maximum level only from 0 to TEX_LOG2, keeps write addresses in range, and holds all inputs idle during reset. Under those conditions, the two-cycle timing relations between ports hold from the first edge after reset.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int BIAS_W = 2;
    typedef logic [BIAS_W-1:0] bias_t;

    // First flat entry of pyramid level lvl for an edge of 2**tex_log2 texels.
    function automatic int level_base(input int tex_log2, input int lvl);
        int acc;
        acc = 0;
        for (int k = 0; k < lvl; k++) begin
            acc += 1 << (2 * (tex_log2 - k));
        end
        return acc;
    endfunction

    function automatic int pyramid_depth(input int tex_log2);
        return level_base(tex_log2, tex_log2 + 1);
    endfunction
endpackage

// File: rtl/tlb_addr_gen.sv
module tlb_addr_gen
    import tlb_pkg::*;
#(
    parameter int TEX_LOG2 = 5,
    parameter int LVL_W    = 3,
    parameter int ADDR_W   = 11
) (
    input  logic [TEX_LOG2-1:0] u,
    input  logic [TEX_LOG2-1:0] v,
    input  logic [LVL_W-1:0]    lvl,
    output logic [ADDR_W-1:0]   addr
);
    localparam int NUM_LVL = TEX_LOG2 + 1;

    logic [ADDR_W-1:0] cand [NUM_LVL];

    // One candidate address per level; the level picks one.
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        localparam int BASE   = level_base(TEX_LOG2, l);
        localparam int ROW_SH = TEX_LOG2 - l;
        assign cand[l] = ADDR_W'(BASE)
                       + (ADDR_W'(v >> l) << ROW_SH)
                       + ADDR_W'(u >> l);
    end

    always_comb begin
        addr = cand[0];
        for (int i = 1; i < NUM_LVL; i++) begin
            if (lvl == LVL_W'(i)) addr = cand[i];
        end
    end
endmodule

// File: rtl/tlb_bias_mem.sv
module tlb_bias_mem
    import tlb_pkg::*;
#(
    parameter int DEPTH  = 1365,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  bias_t             wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output bias_t             rd_data
);
    bias_t mem [DEPTH];
    bias_t rd_q;

    // Storage array: a read issued at the edge of a write returns the old entry.
    always_ff @(posedge clk) begin
        if (rd_en) rd_q <= mem[rd_addr];
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = rd_q;

    p_wr_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < DEPTH));

    p_rd_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_addr) < DEPTH));
endmodule

// File: rtl/tlb_adjust.sv
module tlb_adjust
    import tlb_pkg::*;
#(
    parameter int TEX_LOG2 = 5,
    parameter int LVL_W    = 3
) (
    input  logic [LVL_W-1:0]    lod_int,
    input  logic [LVL_W-1:0]    max_lvl,
    input  bias_t               bias,
    input  logic [TEX_LOG2-1:0] u,
    input  logic [TEX_LOG2-1:0] v,
    output logic [LVL_W-1:0]    lvl_lo,
    output logic [LVL_W-1:0]    lvl_hi,
    output logic                clamped,
    output logic [TEX_LOG2-1:0] u_lo,
    output logic [TEX_LOG2-1:0] v_lo,
    output logic [TEX_LOG2-1:0] u_hi,
    output logic [TEX_LOG2-1:0] v_hi
);
    localparam int SUM_W = LVL_W + 2;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum     = SUM_W'(lod_int) + SUM_W'(bias);
        clamped = sum > SUM_W'(max_lvl);
        lvl_lo  = clamped ? max_lvl : sum[LVL_W-1:0];
        lvl_hi  = (lvl_lo < max_lvl) ? lvl_lo + LVL_W'(1) : lvl_lo;
        u_lo    = u >> lvl_lo;
        v_lo    = v >> lvl_lo;
        u_hi    = u >> lvl_hi;
        v_hi    = v >> lvl_hi;
    end
endmodule

// File: rtl/tex_lod_bias_stage.sv
module tex_lod_bias_stage
    import tlb_pkg::*;
#(
    parameter  int TEX_LOG2 = 5,
    parameter  int FRAC_W   = 4,
    localparam int NUM_LVL  = TEX_LOG2 + 1,
    localparam int LVL_W    = $clog2(NUM_LVL),
    localparam int DEPTH    = pyramid_depth(TEX_LOG2),
    localparam int ADDR_W   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [TEX_LOG2-1:0] req_u,
    input  logic [TEX_LOG2-1:0] req_v,
    input  logic [LVL_W-1:0]    req_lod_int,
    input  logic [FRAC_W-1:0]   req_lod_frac,
    input  logic [LVL_W-1:0]    req_max_lvl,
    input  logic                bias_wr_en,
    input  logic [ADDR_W-1:0]   bias_wr_addr,
    input  logic [1:0]          bias_wr_data,
    output logic                out_valid,
    output logic [LVL_W-1:0]    out_lvl_lo,
    output logic [LVL_W-1:0]    out_lvl_hi,
    output logic [FRAC_W-1:0]   out_lod_frac,
    output logic [TEX_LOG2-1:0] out_u_lo,
    output logic [TEX_LOG2-1:0] out_v_lo,
    output logic [TEX_LOG2-1:0] out_u_hi,
    output logic [TEX_LOG2-1:0] out_v_hi,
    output logic                out_clamped
);
    typedef struct packed {
        logic                valid;
        logic [TEX_LOG2-1:0] u;
        logic [TEX_LOG2-1:0] v;
        logic [LVL_W-1:0]    lod_int;
        logic [LVL_W-1:0]    max_lvl;
        logic [FRAC_W-1:0]   frac;
    } s1_t;

    typedef struct packed {
        logic                valid;
        logic [LVL_W-1:0]    lvl_lo;
        logic [LVL_W-1:0]    lvl_hi;
        logic                clamped;
        logic [FRAC_W-1:0]   frac;
        logic [TEX_LOG2-1:0] u_lo;
        logic [TEX_LOG2-1:0] v_lo;
        logic [TEX_LOG2-1:0] u_hi;
        logic [TEX_LOG2-1:0] v_hi;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [LVL_W-1:0]    look_lvl;
    logic [ADDR_W-1:0]   rd_addr;
    bias_t               bias;
    logic [LVL_W-1:0]    adj_lo, adj_hi;
    logic                adj_clamped;
    logic [TEX_LOG2-1:0] adj_u_lo, adj_v_lo, adj_u_hi, adj_v_hi;

    // Lookup level: requested level, never beyond the texture or the pyramid.
    always_comb begin
        look_lvl = req_lod_int;
        if (look_lvl > req_max_lvl)           look_lvl = req_max_lvl;
        if (look_lvl > LVL_W'(TEX_LOG2))      look_lvl = LVL_W'(TEX_LOG2);
    end

    tlb_addr_gen #(
        .TEX_LOG2 (TEX_LOG2),
        .LVL_W    (LVL_W),
        .ADDR_W   (ADDR_W)
    ) u_addr (
        .u    (req_u),
        .v    (req_v),
        .lvl  (look_lvl),
        .addr (rd_addr)
    );

    tlb_bias_mem #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bias_wr_en),
        .wr_addr (bias_wr_addr),
        .wr_data (bias_wr_data),
        .rd_en   (req_valid),
        .rd_addr (rd_addr),
        .rd_data (bias)
    );

    tlb_adjust #(
        .TEX_LOG2 (TEX_LOG2),
        .LVL_W    (LVL_W)
    ) u_adj (
        .lod_int (st_q.s1.lod_int),
        .max_lvl (st_q.s1.max_lvl),
        .bias    (bias),
        .u       (st_q.s1.u),
        .v       (st_q.s1.v),
        .lvl_lo  (adj_lo),
        .lvl_hi  (adj_hi),
        .clamped (adj_clamped),
        .u_lo    (adj_u_lo),
        .v_lo    (adj_v_lo),
        .u_hi    (adj_u_hi),
        .v_hi    (adj_v_hi)
    );

    // Next state: stage 1 holds the request while the bias is read,
    // stage 2 holds the adjusted result.
    always_comb begin
        st_d = st_q;
        st_d.s1.valid = req_valid;
        if (req_valid) begin
            st_d.s1.u       = req_u;
            st_d.s1.v       = req_v;
            st_d.s1.lod_int = req_lod_int;
            st_d.s1.max_lvl = req_max_lvl;
            st_d.s1.frac    = req_lod_frac;
        end
        st_d.s2.valid = st_q.s1.valid;
        if (st_q.s1.valid) begin
            st_d.s2.lvl_lo  = adj_lo;
            st_d.s2.lvl_hi  = adj_hi;
            st_d.s2.clamped = adj_clamped;
            st_d.s2.frac    = st_q.s1.frac;
            st_d.s2.u_lo    = adj_u_lo;
            st_d.s2.v_lo    = adj_v_lo;
            st_d.s2.u_hi    = adj_u_hi;
            st_d.s2.v_hi    = adj_v_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.s2.valid;
    assign out_lvl_lo   = st_q.s2.lvl_lo;
    assign out_lvl_hi   = st_q.s2.lvl_hi;
    assign out_lod_frac = st_q.s2.frac;
    assign out_u_lo     = st_q.s2.u_lo;
    assign out_v_lo     = st_q.s2.v_lo;
    assign out_u_hi     = st_q.s2.u_hi;
    assign out_v_hi     = st_q.s2.v_hi;
    assign out_clamped  = st_q.s2.clamped;

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid, 2) |-> out_valid);

    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid, 2));

    p_coarser_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_clamped) |-> (out_lvl_lo >= $past(req_lod_int, 2)));

    p_within_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_lvl_lo <= $past(req_max_lvl, 2)));

    p_clamp_at_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_clamped) |-> (out_lvl_lo == $past(req_max_lvl, 2)));

    p_coord_scale_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_u_lo == ($past(req_u, 2) >> out_lvl_lo)));

    p_hi_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_lvl_hi == out_lvl_lo) || (out_lvl_hi == out_lvl_lo + LVL_W'(1))));

    p_frac_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_lod_frac == $past(req_lod_frac, 2)));
endmodule

// File: tb/tex_lod_bias_stage_test.sv
`timescale 1ns/1ps
module tex_lod_bias_stage_test;
    localparam int T  = 5;
    localparam int FW = 4;
    localparam int NL = T + 1;
    localparam int LW = 3;

    function automatic int lvl_start(int lvl);
        int acc;
        acc = 0;
        for (int k = 0; k < lvl; k++) acc += (1 << (T - k)) * (1 << (T - k));
        return acc;
    endfunction

    localparam int DEPTH = lvl_start(NL);
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 0;
    logic          rst_n = 0;
    logic          req_valid = 0;
    logic [T-1:0]  req_u = '0, req_v = '0;
    logic [LW-1:0] req_lod_int = '0, req_max_lvl = '0;
    logic [FW-1:0] req_lod_frac = '0;
    logic          bias_wr_en = 0;
    logic [AW-1:0] bias_wr_addr = '0;
    logic [1:0]    bias_wr_data = '0;
    logic          out_valid;
    logic [LW-1:0] out_lvl_lo, out_lvl_hi;
    logic [FW-1:0] out_lod_frac;
    logic [T-1:0]  out_u_lo, out_v_lo, out_u_hi, out_v_hi;
    logic          out_clamped;

    tex_lod_bias_stage #(.TEX_LOG2(T), .FRAC_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_u(req_u), .req_v(req_v), .req_lod_int(req_lod_int),
        .req_lod_frac(req_lod_frac), .req_max_lvl(req_max_lvl),
        .bias_wr_en(bias_wr_en), .bias_wr_addr(bias_wr_addr),
        .bias_wr_data(bias_wr_data), .out_valid(out_valid),
        .out_lvl_lo(out_lvl_lo), .out_lvl_hi(out_lvl_hi),
        .out_lod_frac(out_lod_frac), .out_u_lo(out_u_lo), .out_v_lo(out_v_lo),
        .out_u_hi(out_u_hi), .out_v_hi(out_v_hi), .out_clamped(out_clamped)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int    due;
        int    lo, hi, frac, ulo, vlo, uhi, vhi, clamp;
        string note;
    } exp_t;

    exp_t  sb[$];
    int    model [DEPTH];
    int    cyc = 0;
    int    errors = 0;
    int    checks = 0;
    bit    monitor_on = 0;
    bit    finished = 0;

    always @(posedge clk) cyc++;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int entry(int lvl, int u, int v);
        return lvl_start(lvl) + (v >> lvl) * (1 << (T - lvl)) + (u >> lvl);
    endfunction

    // Driver: drives one request (and optionally a write) and queues the expectation.
    task automatic send(int u, int v, int lod, int frac, int mx, string note,
                        int wa = -1, int wd = 0);
        exp_t e;
        int lk, b, sum;
        lk = lod;
        if (lk > mx) lk = mx;
        b = model[entry(lk, u, v)];
        sum = lod + b;
        e.clamp = (sum > mx) ? 1 : 0;
        e.lo    = e.clamp ? mx : sum;
        e.hi    = (e.lo < mx) ? e.lo + 1 : e.lo;
        e.ulo   = u >> e.lo;
        e.vlo   = v >> e.lo;
        e.uhi   = u >> e.hi;
        e.vhi   = v >> e.hi;
        e.frac  = frac;
        e.due   = cyc + 2;
        e.note  = note;
        sb.push_back(e);
        req_u        = T'(u);
        req_v        = T'(v);
        req_lod_int  = LW'(lod);
        req_lod_frac = FW'(frac);
        req_max_lvl  = LW'(mx);
        req_valid    = 1;
        if (wa >= 0) begin
            bias_wr_en   = 1;
            bias_wr_addr = AW'(wa);
            bias_wr_data = 2'(wd);
            model[wa]    = wd;
        end
        @(negedge clk);
        req_valid  = 0;
        bias_wr_en = 0;
    endtask

    task automatic write_bias(int a, int d);
        bias_wr_en   = 1;
        bias_wr_addr = AW'(a);
        bias_wr_data = 2'(d);
        model[a]     = d;
        @(negedge clk);
        bias_wr_en = 0;
    endtask

    // Monitor: compares each result in the cycle the requirements place it.
    always @(negedge clk) begin
        if (monitor_on) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                check({"R1 out_valid ", e.note}, int'(out_valid), 1);
                check({"R3 R4 out_lvl_lo ", e.note}, int'(out_lvl_lo), e.lo);
                check({"R5 out_clamped ", e.note}, int'(out_clamped), e.clamp);
                check({"R6 out_u_lo ", e.note}, int'(out_u_lo), e.ulo);
                check({"R6 out_v_lo ", e.note}, int'(out_v_lo), e.vlo);
                check({"R7 out_lvl_hi ", e.note}, int'(out_lvl_hi), e.hi);
                check({"R7 out_u_hi ", e.note}, int'(out_u_hi), e.uhi);
                check({"R7 out_v_hi ", e.note}, int'(out_v_hi), e.vhi);
                check({"R8 out_lod_frac ", e.note}, int'(out_lod_frac), e.frac);
            end else if (out_valid) begin
                check("R1 unexpected out_valid", 1, 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int w, old;
        repeat (5) @(negedge clk);
        check("R9 out_valid in reset", int'(out_valid), 0);
        rst_n = 1;
        @(negedge clk);
        check("R9 out_valid after reset", int'(out_valid), 0);
        check("R9 out_lvl_lo after reset", int'(out_lvl_lo), 0);
        check("R9 out_u_lo after reset", int'(out_u_lo), 0);
        check("R9 out_clamped after reset", int'(out_clamped), 0);
        monitor_on = 1;

        // R2 preload of the whole pyramid
        for (int a = 0; a < DEPTH; a++) write_bias(a, (a ^ (a >> 2) ^ (a >> 5)) & 3);

        // R4 known biases at chosen entries
        write_bias(entry(0, 31, 31), 2);
        write_bias(entry(4, 0, 0), 3);
        write_bias(entry(2, 12, 20), 0);
        write_bias(entry(3, 8, 8), 1);
        send(31, 31, 0, 5, 5, "bias2 fine");
        send(0, 0, 4, 9, 5, "clamp at max");
        send(12, 20, 2, 0, 5, "bias0 unchanged");
        send(8, 8, 3, 15, 4, "reaches max no clamp");
        send(17, 3, 7, 3, 2, "lod above max");
        send(5, 29, 0, 1, 0, "single level texture");
        send(31, 0, 5, 7, 5, "top level");

        // R2 read-during-write old data, then new data
        w   = entry(1, 10, 6);
        old = model[w];
        send(10, 6, 1, 2, 5, "R2 old-data", w, (old + 2) & 3);
        send(10, 6, 1, 2, 5, "R2 new-data");

        // R1 back-to-back mixed traffic with interleaved writes
        for (int i = 0; i < 400; i++) begin
            int mx, lod;
            mx  = $urandom_range(T, 0);
            lod = $urandom_range(7, 0);
            if ((i % 5) == 0)
                send($urandom_range(31, 0), $urandom_range(31, 0), lod,
                     $urandom_range(15, 0), mx, "mixed+write",
                     $urandom_range(DEPTH - 1, 0), $urandom_range(3, 0));
            else
                send($urandom_range(31, 0), $urandom_range(31, 0), lod,
                     $urandom_range(15, 0), mx, "mixed");
            if ((i % 37) == 36) repeat (2) @(negedge clk);
        end

        repeat (6) @(negedge clk);
        check("R1 results drained", sb.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule